// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block is a small, fully associative translation cache that keeps recent virtual-to-physical page mappings. Every entry has its own page-size code, so one entry may map a 4 KB, 16 KB, 64 KB or 1 MB page. All entries are compared with the incoming virtual address at the same time. On a hit, the physical address comes out in the same cycle. A single 1 MB entry translates every address in its region, and so takes the place of 256 entries of 4 KB.

A request to an external page-walk agent goes out with every lookup, before the result of the compare is known. When the lookup hits, a cancel strobe withdraws that request in the same cycle. When the lookup misses, the walker finishes on its own time and then presents a fill. The fill is written into the buffer, and the translated address of the fill is passed straight back to the requester. A synchronous flush clears every entry in one cycle.

A fill first looks for entries that cover any part of the new page. If there are none, it takes a free slot. If every slot is in use, it takes the slot named by a rotating pointer.

Top module: `tlb_multisize`

## Requirements
- R1: After reset every entry is invalid, the rotating pointer is at entry 0, and every lookup misses.
- R2: A valid lookup that matches a valid entry raises `lk_hit_o` in the same cycle. `lk_paddr_o` is then formed from the entry's physical base above the page-offset bits and the lookup address below them.
- R3: Size code 0 is a 4 KB page with offset bits [11:0]. Code 1 is 16 KB with bits [13:0]. Code 2 is 64 KB with bits [15:0]. Code 3 is 1 MB with bits [19:0]. The compare ignores the offset bits of the entry's own size.
- R4: `walk_req_o` follows `lk_valid_i` in every cycle, and `walk_vaddr_o` carries the lookup address. `walk_cancel_o` is high in exactly those cycles in which a valid lookup hits.
- R5: A lookup that matches no valid entry drives `lk_hit_o` to 0 and `lk_paddr_o` to 0.
- R6: A fill is visible to lookups from the next cycle on. In the fill's own cycle, `rsp_valid_o` is high and `rsp_paddr_o` is formed from the fill base and the fill address under the fill's page size.
- R7: Two pages overlap when they agree on every address bit above the larger of their two offsets. A fill rewrites the lowest-indexed valid entry that overlaps the new page and invalidates every other overlapping entry. As a result, no address ever matches two entries.
- R8: A fill that overlaps no valid entry goes into the lowest-indexed invalid entry.
- R9: A fill that overlaps nothing while all entries are valid replaces the entry at the rotating pointer. The pointer then advances by one, wrapping after the last entry. The pointer moves at no other time.
- R10: `flush_i` invalidates all entries at the clock edge. A lookup in the flush cycle misses and does not cancel its walk. A fill in the same cycle is kept, and only its entry remains valid.
- R11: While `lk_valid_i` is low, `lk_hit_o` and `walk_cancel_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_hit_o | output | 1 | Lookup hit, same cycle |
| lk_paddr_o | output | 32 | Translated physical address, 0 on miss |
| walk_req_o | output | 1 | Speculative walk request |
| walk_vaddr_o | output | 32 | Address handed to the walker |
| walk_cancel_o | output | 1 | Withdraws this cycle's walk request |
| fill_valid_i | input | 1 | Walker result strobe |
| fill_vaddr_i | input | 32 | Virtual address that was walked |
| fill_size_i | input | 2 | Page-size code of the result |
| fill_pbase_i | input | 32 | Physical page base of the result |
| rsp_valid_o | output | 1 | Walk result to requester |
| rsp_paddr_o | output | 32 | Physical address of the walked request |

## Verification
The hardest state to reach from the ports is a large page arriving over several small pages that are already cached. To reach it, the stimulus first installs a 4 KB page inside a 1 MB region. It then fills the 1 MB page, and after that a 4 KB page inside the large one, so that overlap replacement is exercised in both directions. Reaching rotating-pointer eviction takes eight disjoint fills followed by a ninth. The first entry's page is then looked up to show that it is gone. A long stream of lookups and fills over a few crowded regions, with mixed sizes, is compared against the behavioural model on every cycle. That stream keeps overlap, refill and flush interacting.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef logic [1:0] pgsz_t;

   localparam int unsigned SHIFT_4K   = 12;
   localparam int unsigned SHIFT_16K  = 14;
   localparam int unsigned SHIFT_64K  = 16;
   localparam int unsigned SHIFT_1M   = 20;
   localparam int unsigned MAX_SHIFT  = SHIFT_1M;

   function automatic int unsigned pg_shift(pgsz_t c);
      case (c)
         2'd0:    return SHIFT_4K;
         2'd1:    return SHIFT_16K;
         2'd2:    return SHIFT_64K;
         default: return SHIFT_1M;
      endcase
   endfunction

   // ones above the page offset for size code c
   function automatic logic [63:0] hi_mask64(pgsz_t c);
      return ~64'd0 << pg_shift(c);
   endfunction

   function automatic pgsz_t coarser(pgsz_t a, pgsz_t b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/tlb_entry.sv
module tlb_entry
   import tlb_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int PA_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush_i,
   input  logic            wr_i,
   input  logic            kill_i,
   input  logic [VA_W-1:0] wr_vaddr_i,
   input  pgsz_t           wr_size_i,
   input  logic [PA_W-1:0] wr_pbase_i,
   input  logic [VA_W-1:0] lk_vaddr_i,
   output logic            valid_o,
   output logic            hit_o,
   output logic            ovl_o,
   output logic [PA_W-1:0] xlat_o
);
   logic            vld_q;
   pgsz_t           sz_q;
   logic [VA_W-1:0] vtag_q;
   logic [PA_W-1:0] ptag_q;

   logic [VA_W-1:0] own_vmask;
   logic [VA_W-1:0] wr_vmask;
   logic [VA_W-1:0] ovl_vmask;
   logic [PA_W-1:0] own_pmask;
   logic [PA_W-1:0] wr_pmask;
   logic [PA_W-1:0] lk_low;

   always_comb begin
      own_vmask = VA_W'(hi_mask64(sz_q));
      wr_vmask  = VA_W'(hi_mask64(wr_size_i));
      ovl_vmask = VA_W'(hi_mask64(coarser(sz_q, wr_size_i)));
      own_pmask = PA_W'(hi_mask64(sz_q));
      wr_pmask  = PA_W'(hi_mask64(wr_size_i));
      lk_low    = PA_W'(lk_vaddr_i) & ~own_pmask;
   end

   assign hit_o   = vld_q && (((lk_vaddr_i ^ vtag_q) & own_vmask) == '0);
   assign ovl_o   = vld_q && (((wr_vaddr_i ^ vtag_q) & ovl_vmask) == '0);
   assign xlat_o  = (ptag_q & own_pmask) | lk_low;
   assign valid_o = vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         sz_q   <= 2'd0;
         vtag_q <= '0;
         ptag_q <= '0;
      end else begin
         if (wr_i) begin
            vld_q  <= 1'b1;
            sz_q   <= wr_size_i;
            vtag_q <= wr_vaddr_i & wr_vmask;
            ptag_q <= wr_pbase_i & wr_pmask;
         end else if (flush_i || kill_i) begin
            vld_q  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fill_i,
   input  logic [N-1:0]  ovl_vec_i,
   input  logic [N-1:0]  valid_vec_i,
   output logic [N-1:0]  wr_vec_o,
   output logic [N-1:0]  kill_vec_o,
   output logic [IW-1:0] rr_o
);
   logic          ovl_any, free_any;
   logic [IW-1:0] ovl_idx, free_idx;
   logic [IW-1:0] rr_q, rr_inc;
   logic          use_rr;

   tlb_pick #(.N(N), .IW(IW)) u_ovl (
      .req_i(ovl_vec_i), .any_o(ovl_any), .idx_o(ovl_idx));

   tlb_pick #(.N(N), .IW(IW)) u_free (
      .req_i(~valid_vec_i), .any_o(free_any), .idx_o(free_idx));

   assign use_rr = fill_i && !ovl_any && !free_any;

   always_comb begin
      wr_vec_o = '0;
      if (fill_i) begin
         if (ovl_any)       wr_vec_o[ovl_idx]  = 1'b1;
         else if (free_any) wr_vec_o[free_idx] = 1'b1;
         else               wr_vec_o[rr_q]     = 1'b1;
      end
      kill_vec_o = fill_i ? (ovl_vec_i & ~wr_vec_o) : '0;
   end

   generate
      if ((1 << IW) == N) begin : g_rr_pow2
         assign rr_inc = rr_q + 1'b1;
      end else begin : g_rr_wrap
         assign rr_inc = (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      rr_q <= '0;
      else if (use_rr) rr_q <= rr_inc;
   end

   assign rr_o = rr_q;
endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize
   import tlb_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int ENTRIES = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush_i,
   input  logic            lk_valid_i,
   input  logic [VA_W-1:0] lk_vaddr_i,
   output logic            lk_hit_o,
   output logic [PA_W-1:0] lk_paddr_o,
   output logic            walk_req_o,
   output logic [VA_W-1:0] walk_vaddr_o,
   output logic            walk_cancel_o,
   input  logic            fill_valid_i,
   input  logic [VA_W-1:0] fill_vaddr_i,
   input  logic [1:0]      fill_size_i,
   input  logic [PA_W-1:0] fill_pbase_i,
   output logic            rsp_valid_o,
   output logic [PA_W-1:0] rsp_paddr_o
);
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("tlb_multisize: ENTRIES must be at least 2");
      end
      if (VA_W <= int'(MAX_SHIFT) || VA_W > 64) begin : g_bad_va
         $error("tlb_multisize: VA_W must exceed the largest page offset and be at most 64");
      end
      if (PA_W <= int'(MAX_SHIFT) || PA_W > 64) begin : g_bad_pa
         $error("tlb_multisize: PA_W must exceed the largest page offset and be at most 64");
      end
   endgenerate

   logic [ENTRIES-1:0] valid_vec, hit_vec, ovl_vec, wr_vec, kill_vec;
   logic [PA_W-1:0]    xlat [ENTRIES];
   logic               hit_any;
   logic [IW-1:0]      hit_idx;
   logic [IW-1:0]      rr_ptr;
   logic               lk_hit;
   logic [PA_W-1:0]    rsp_mask;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         tlb_entry #(.VA_W(VA_W), .PA_W(PA_W)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush_i    (flush_i),
            .wr_i       (wr_vec[g]),
            .kill_i     (kill_vec[g]),
            .wr_vaddr_i (fill_vaddr_i),
            .wr_size_i  (fill_size_i),
            .wr_pbase_i (fill_pbase_i),
            .lk_vaddr_i (lk_vaddr_i),
            .valid_o    (valid_vec[g]),
            .hit_o      (hit_vec[g]),
            .ovl_o      (ovl_vec[g]),
            .xlat_o     (xlat[g])
         );
      end
   endgenerate

   tlb_pick #(.N(ENTRIES), .IW(IW)) u_hit_pick (
      .req_i(hit_vec), .any_o(hit_any), .idx_o(hit_idx));

   tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_i      (fill_valid_i),
      .ovl_vec_i   (ovl_vec),
      .valid_vec_i (valid_vec),
      .wr_vec_o    (wr_vec),
      .kill_vec_o  (kill_vec),
      .rr_o        (rr_ptr)
   );

   assign lk_hit        = lk_valid_i && !flush_i && hit_any;
   assign lk_hit_o      = lk_hit;
   assign lk_paddr_o    = lk_hit ? xlat[hit_idx] : '0;
   assign walk_req_o    = lk_valid_i;
   assign walk_vaddr_o  = lk_vaddr_i;
   assign walk_cancel_o = lk_hit;

   assign rsp_mask    = PA_W'(hi_mask64(fill_size_i));
   assign rsp_valid_o = fill_valid_i;
   assign rsp_paddr_o = (fill_pbase_i & rsp_mask) | (PA_W'(fill_vaddr_i) & ~rsp_mask);
endmodule

// File: rtl/tlb_multisize_chk.sv
module tlb_multisize_chk #(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int ENTRIES = 8,
   parameter int IW      = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush_i,
   input logic               lk_valid_i,
   input logic [VA_W-1:0]    lk_vaddr_i,
   input logic               lk_hit_o,
   input logic [PA_W-1:0]    lk_paddr_o,
   input logic               walk_req_o,
   input logic               walk_cancel_o,
   input logic               fill_valid_i,
   input logic [ENTRIES-1:0] hit_vec,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [IW-1:0]      rr_ptr
);
   assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit_o |-> lk_paddr_o[11:0] == lk_vaddr_i[11:0]);

   assert_cancel_only_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      walk_cancel_o |-> (lk_hit_o && walk_req_o));

   assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid_i |=> valid_vec != '0);

   assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   assert_pointer_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_valid_i |=> $stable(rr_ptr));

   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i && !fill_valid_i) |=> valid_vec == '0);

   assert_flush_misses_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !lk_hit_o);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid_i |-> (!lk_hit_o && !walk_cancel_o));
endmodule

bind tlb_multisize tlb_multisize_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENTRIES), .IW(IW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .flush_i       (flush_i),
   .lk_valid_i    (lk_valid_i),
   .lk_vaddr_i    (lk_vaddr_i),
   .lk_hit_o      (lk_hit_o),
   .lk_paddr_o    (lk_paddr_o),
   .walk_req_o    (walk_req_o),
   .walk_cancel_o (walk_cancel_o),
   .fill_valid_i  (fill_valid_i),
   .hit_vec       (hit_vec),
   .valid_vec     (valid_vec),
   .rr_ptr        (rr_ptr)
);

// File: tb/tlb_multisize_test.sv
module tlb_multisize_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic        lk_valid_i = 1'b0;
   logic [31:0] lk_vaddr_i = '0;
   logic        lk_hit_o;
   logic [31:0] lk_paddr_o;
   logic        walk_req_o;
   logic [31:0] walk_vaddr_o;
   logic        walk_cancel_o;
   logic        fill_valid_i = 1'b0;
   logic [31:0] fill_vaddr_i = '0;
   logic [1:0]  fill_size_i = '0;
   logic [31:0] fill_pbase_i = '0;
   logic        rsp_valid_o;
   logic [31:0] rsp_paddr_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference state
   bit          m_valid [8];
   logic [31:0] m_vb [8];
   logic [31:0] m_pb [8];
   int          m_sz [8];
   int          m_rr = 0;
   logic [31:0] seed = 32'h1357_2468;

   always #2 clk = ~clk;

   tlb_multisize uut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i),
      .lk_hit_o(lk_hit_o), .lk_paddr_o(lk_paddr_o),
      .walk_req_o(walk_req_o), .walk_vaddr_o(walk_vaddr_o), .walk_cancel_o(walk_cancel_o),
      .fill_valid_i(fill_valid_i), .fill_vaddr_i(fill_vaddr_i),
      .fill_size_i(fill_size_i), .fill_pbase_i(fill_pbase_i),
      .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o));

   function automatic int shf(int c);
      case (c)
         0: return 12;
         1: return 14;
         2: return 16;
         default: return 20;
      endcase
   endfunction

   function automatic logic [31:0] lowmask(int c);
      return (32'h1 << shf(c)) - 32'h1;
   endfunction

   task automatic chk(string tg, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tg, act, exp, $time);
      end
   endtask

   task automatic step(string tg, bit fl, bit lv, logic [31:0] va,
                       bit fv, logic [31:0] fva, int fsz, logic [31:0] fpb);
      bit          mh;
      logic [31:0] mp;
      int          tgt;
      bit          found;
      @(negedge clk);
      flush_i = fl; lk_valid_i = lv; lk_vaddr_i = va;
      fill_valid_i = fv; fill_vaddr_i = fva; fill_size_i = 2'(fsz); fill_pbase_i = fpb;
      #1;
      mh = 0; mp = '0;
      if (lv && !fl) begin
         for (int i = 0; i < 8; i++) begin
            if (!mh && m_valid[i] && ((va >> shf(m_sz[i])) == (m_vb[i] >> shf(m_sz[i])))) begin
               mh = 1;
               mp = (m_pb[i] & ~lowmask(m_sz[i])) | (va & lowmask(m_sz[i]));
            end
         end
      end
      chk(tg, lk_hit_o, mh);
      chk(tg, lk_paddr_o, mp);
      chk("R4 walk_req", walk_req_o, lv);
      chk("R4 walk_cancel", walk_cancel_o, lv && mh);
      chk("R4 walk_vaddr", walk_vaddr_o, va);
      chk("R6 rsp_valid", rsp_valid_o, fv);
      if (fv) chk("R6 rsp_paddr", rsp_paddr_o, (fpb & ~lowmask(fsz)) | (fva & lowmask(fsz)));
      // model update for the coming edge
      tgt = -1;
      if (fv) begin
         found = 0;
         for (int i = 0; i < 8; i++) begin
            int s;
            s = (m_sz[i] > fsz) ? shf(m_sz[i]) : shf(fsz);
            if (m_valid[i] && ((fva >> s) == (m_vb[i] >> s))) begin
               if (!found) begin tgt = i; found = 1; end
               else m_valid[i] = 0;
            end
         end
         if (!found) begin
            for (int i = 0; i < 8; i++) if (tgt < 0 && !m_valid[i]) tgt = i;
            if (tgt < 0) begin tgt = m_rr; m_rr = (m_rr + 1) % 8; end
         end
      end
      if (fl) for (int i = 0; i < 8; i++) m_valid[i] = 0;
      if (tgt >= 0) begin
         m_valid[tgt] = 1; m_sz[tgt] = fsz;
         m_vb[tgt] = fva & ~lowmask(fsz); m_pb[tgt] = fpb & ~lowmask(fsz);
      end
   endtask

   task automatic look(string tg, logic [31:0] va);
      step(tg, 0, 1, va, 0, '0, 0, '0);
   endtask

   task automatic fill(string tg, logic [31:0] va, int sz, logic [31:0] pb);
      step(tg, 0, 0, '0, 1, va, sz, pb);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin m_valid[i] = 0; m_sz[i] = 0; m_vb[i] = '0; m_pb[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: nothing cached after reset
      look("R1 reset miss", 32'h0000_0000);
      look("R1 reset miss", 32'h1234_5678);
      // R5 miss, R6 fill then hit (R2, R3 4K bounds)
      look("R5 miss", 32'h1234_5678);
      fill("R6 fill 4K", 32'h1234_5678, 0, 32'hABCD_E000);
      look("R2 hit 4K", 32'h1234_5FFF);
      look("R3 4K upper bound", 32'h1234_6000);
      look("R3 4K lower bound", 32'h1234_4FFF);
      // R3 other sizes
      fill("R6 fill 16K", 32'h4000_8000, 1, 32'h0001_0000);
      look("R3 16K hit", 32'h4000_BFFC);
      look("R3 16K miss", 32'h4000_C000);
      fill("R6 fill 64K", 32'h5002_0000, 2, 32'h7777_0000);
      look("R3 64K hit", 32'h5002_FFFF);
      look("R3 64K miss", 32'h5003_0000);
      // R7: 1M over cached 4K page, then 4K inside 1M
      fill("R7 1M over 4K", 32'h1230_0000, 3, 32'h8000_0000);
      look("R7 1M covers old 4K", 32'h1234_5678);
      look("R3 1M top", 32'h123F_FFFF);
      look("R3 1M outside", 32'h1240_0000);
      fill("R7 4K inside 1M", 32'h1238_8000, 0, 32'h0BAD_0000);
      look("R7 small replaces large", 32'h1238_8ABC);
      look("R7 large gone", 32'h1234_5678);
      // R11 idle lookups
      step("R11 idle", 0, 0, 32'h5002_0000, 0, '0, 0, '0);
      // R10 flush with hitting lookup, then miss
      step("R10 flush lookup", 1, 1, 32'h5002_0010, 0, '0, 0, '0);
      look("R10 after flush", 32'h5002_0010);
      look("R10 after flush", 32'h4000_8000);
      // R8/R9: fill all eight, then a ninth and tenth
      for (int i = 0; i < 8; i++) fill("R8 free slot", 32'h6000_0000 + 32'(i) * 32'h1_0000, 0, 32'h0100_0000 * 32'(i + 1));
      for (int i = 0; i < 8; i++) look("R8 all present", 32'h6000_0004 + 32'(i) * 32'h1_0000);
      fill("R9 evict rr", 32'h7000_0000, 0, 32'hC000_0000);
      look("R9 slot0 evicted", 32'h6000_0004);
      look("R9 new present", 32'h7000_0123);
      fill("R9 evict next", 32'h7100_0000, 0, 32'hC100_0000);
      look("R9 slot1 evicted", 32'h6001_0004);
      look("R9 slot2 kept", 32'h6002_0004);
      // R10 flush together with fill
      step("R10 flush+fill", 1, 0, '0, 1, 32'h2000_0000, 2, 32'h3000_0000);
      look("R10 fill survives", 32'h2000_1234);
      look("R10 others gone", 32'h6002_0004);
      // R8: holes from overlap then lowest free slot
      fill("R8 refill", 32'h2100_0000, 0, 32'h3100_0000);
      look("R8 refill hit", 32'h2100_0040);

      // mixed random traffic over crowded regions
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r1, r2, r3;
         seed = seed * 32'd1103515245 + 32'd12345; r1 = seed;
         seed = seed * 32'd1103515245 + 32'd12345; r2 = seed;
         seed = seed * 32'd1103515245 + 32'd12345; r3 = seed;
         step("R2 mixed", (r1[7:0] == 8'h00), r1[9] | r1[10],
              {6'h10, r2[31:30], 4'h0, r2[19:0]},
              (r1[13:11] == 3'b000),
              {6'h10, r3[31:30], 4'h0, r3[19:0]}, int'(r1[17:16]),
              {r3[15:0], r2[15:0]});
      end

      done = 1;
      summary();
      $finish;
   end
endmodule